// File: doc/BRIEF.md
# Region Permission Checker

This block decides, one bus access at a time, whether a memory access is allowed under a set of programmable protection regions. Each access comes with an address, a kind (data read, data write or instruction fetch), a privilege flag and a flag that marks a hard-fault or NMI handler as running. The region settings come in from a separate register block as flat vectors. The block gives back a permit or fault decision, tells instruction faults apart from data faults, and reports which region decided the access. It also passes that region's memory-type attribute bits through, but it does not act on them.

A region spans 2^(SIZE+1) bytes. Its base is always taken as aligned to that span. It is cut into eight equal slices, and each slice can be switched off. Where regions overlap, the one with the highest index wins. A privileged background map sits beneath all regions. The response is registered and comes one clock after the request.

Top module: `region_guard`

## Requirements
- R1: A response appears on the clock after each request: `rsp_valid_o` is 1 exactly one cycle after `req_valid_i` was 1. In a cycle that follows no request, `rsp_valid_o`, `permit_o` and `fault_o` are 0. While a response is valid, exactly one of `permit_o` and `fault_o` is 1.
- R2: An enabled region with size code S covers 2^(S+1) bytes, starting at its base with the low S+1 address bits cleared. The low base bits are ignored, so a misaligned base still covers the aligned block.
- R3: Bit j of a region's 8-bit slice-disable mask removes slice j, which is the j-th eighth counted from the low address. An address in a removed slice does not match that region. The mask has no effect when the region is 256 bytes or smaller (S <= 7).
- R4: A disabled region never matches. When several enabled regions match, the highest-numbered one decides the access. `hit_o` is then 1, `region_o` gives its index and `attr_o` gives its 6 attribute bits. With no match, all three are 0.
- R5: With `unit_en_i` at 0, every access is permitted, and `hit_o`, `region_o` and `attr_o` are 0.
- R6: With no matching region, an access is permitted only when it is privileged and `bg_en_i` is 1. Any other unmatched access faults. Instruction fetches are included in this rule.
- R7: Permission codes, as `rgn_ap_i` values: 0 and 4 give no access. 1 gives read/write to privileged code only. 2 gives privileged read/write and unprivileged read. 3 gives read/write to both levels. 5 gives privileged read only. 6 and 7 give read only to both levels. The kind codes are 0 for read, 1 for write and 2 for fetch.
- R8: A fetch from a region whose execute-never bit is set faults. A fetch also faults wherever a read would be denied at that privilege.
- R9: While `req_handler_i` is 1 and `handler_en_i` is 0, checking is bypassed and the access is permitted with no hit. When `handler_en_i` is 1, handler accesses are checked as normal.
- R10: `fault_fetch_o` is 1 when a response faults on an instruction fetch. It is 0 on data faults and on permitted accesses.
- R11: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is presented |
| req_addr_i | input | ADDR_W | Access address |
| req_kind_i | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv_i | input | 1 | Access is privileged |
| req_handler_i | input | 1 | Hard-fault or NMI handler running |
| unit_en_i | input | 1 | Protection unit enable |
| bg_en_i | input | 1 | Privileged background map enable |
| handler_en_i | input | 1 | Keep checking inside fault handlers |
| rgn_en_i | input | NREG | Per-region enable |
| rgn_base_i | input | NREG*ADDR_W | Per-region base addresses |
| rgn_size_i | input | NREG*5 | Per-region size codes |
| rgn_srd_i | input | NREG*8 | Per-region slice-disable masks |
| rgn_ap_i | input | NREG*3 | Per-region permission codes |
| rgn_xn_i | input | NREG | Per-region execute-never |
| rgn_attr_i | input | NREG*6 | Per-region memory attributes (pass-through) |
| rsp_valid_o | output | 1 | Response valid |
| permit_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access denied |
| fault_fetch_o | output | 1 | Denied access was an instruction fetch |
| hit_o | output | 1 | A region decided the access |
| region_o | output | IDX_W | Index of the deciding region |
| attr_o | output | 6 | Attributes of the deciding region |

## Verification
Addresses are swept in fixed steps across and past each region's edges. At every address the bench tries all three access kinds at both privilege levels. One sweep uses a misaligned base under each of the eight permission codes, which separates span and alignment errors from permission-table errors. A second sweep runs over a 1 KB region with a hole pattern, and over 512-byte and 256-byte regions with every slice disabled, which separates slice indexing from the size threshold. Further sweeps use nested overlapping regions (one of them disabled, one of them covering everything), the unit switched off, unmatched addresses with the background map on and off, and handler accesses with the bypass on and off. Together these separate priority resolution from the bypass paths.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  localparam int unsigned SIZE_W = 5;
  localparam int unsigned SRD_W  = 8;
  localparam int unsigned AP_W   = 3;
  localparam int unsigned ATTR_W = 6;
  localparam int unsigned SUB_MIN_SPAN = 9;  // log2 span above which slices count
endpackage

// File: rtl/rg_region_match.sv
module rg_region_match
  import region_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SRD_W-1:0]  srd_i,
  output logic              hit_o
);
  logic [5:0]        span_log2;
  logic [ADDR_W-1:0] hi_mask;
  logic [2:0]        slice;
  logic              in_span;
  logic              slice_off;

  always_comb begin
    span_log2 = 6'(size_i) + 6'd1;
    hi_mask   = {ADDR_W{1'b1}} << span_log2;
    in_span   = ((addr_i ^ base_i) & hi_mask) == '0;
    slice     = 3'(addr_i >> (span_log2 - 6'd3));
    slice_off = (span_log2 >= 6'(SUB_MIN_SPAN)) && srd_i[slice];
    hit_o     = en_i && in_span && !slice_off;
  end
endmodule

// File: rtl/rg_prio_pick.sv
module rg_prio_pick #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0]  hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  // later index overrides earlier: highest match wins
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    for (int i = 0; i < int'(NREG); i++) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        win_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rg_perm_eval.sv
module rg_perm_eval
  import region_guard_pkg::*;
(
  input  logic [AP_W-1:0] ap_i,
  input  logic            xn_i,
  input  logic [1:0]      kind_i,
  input  logic            priv_i,
  output logic            ok_o
);
  logic rd_ok, wr_ok;

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    unique case (ap_i)
      3'd1: begin rd_ok = priv_i; wr_ok = priv_i; end
      3'd2: begin rd_ok = 1'b1;   wr_ok = priv_i; end
      3'd3: begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
      3'd5: rd_ok = priv_i;
      3'd6, 3'd7: rd_ok = 1'b1;
      default: ;  // 0 and reserved 4: no access
    endcase
    case (acc_kind_e'(kind_i))
      ACC_WRITE: ok_o = wr_ok;
      ACC_FETCH: ok_o = rd_ok && !xn_i;
      default:   ok_o = rd_ok;
    endcase
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREG   = 8,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [1:0]               req_kind_i,
  input  logic                     req_priv_i,
  input  logic                     req_handler_i,
  input  logic                     unit_en_i,
  input  logic                     bg_en_i,
  input  logic                     handler_en_i,
  input  logic [NREG-1:0]          rgn_en_i,
  input  logic [NREG*ADDR_W-1:0]   rgn_base_i,
  input  logic [NREG*SIZE_W-1:0]   rgn_size_i,
  input  logic [NREG*SRD_W-1:0]    rgn_srd_i,
  input  logic [NREG*AP_W-1:0]     rgn_ap_i,
  input  logic [NREG-1:0]          rgn_xn_i,
  input  logic [NREG*ATTR_W-1:0]   rgn_attr_i,
  output logic                     rsp_valid_o,
  output logic                     permit_o,
  output logic                     fault_o,
  output logic                     fault_fetch_o,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         region_o,
  output logic [ATTR_W-1:0]        attr_o
);
  logic [NREG-1:0]   hits;
  logic              any_hit;
  logic [IDX_W-1:0]  win;
  logic [AP_W-1:0]   ap_sel;
  logic              xn_sel;
  logic [ATTR_W-1:0] attr_sel;
  logic              rgn_ok;
  logic              active;
  logic              permit_c, hit_c;
  logic [IDX_W-1:0]  region_c;
  logic [ATTR_W-1:0] attr_c;

  for (genvar g = 0; g < int'(NREG); g++) begin : g_rgn
    rg_region_match #(.ADDR_W(ADDR_W)) u_match (
      .addr_i (req_addr_i),
      .en_i   (rgn_en_i[g]),
      .base_i (rgn_base_i[g*ADDR_W +: ADDR_W]),
      .size_i (rgn_size_i[g*SIZE_W +: SIZE_W]),
      .srd_i  (rgn_srd_i[g*SRD_W +: SRD_W]),
      .hit_o  (hits[g])
    );
  end

  rg_prio_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .hit_i (hits),
    .any_o (any_hit),
    .win_o (win)
  );

  always_comb begin
    ap_sel   = rgn_ap_i[int'(win)*AP_W +: AP_W];
    xn_sel   = rgn_xn_i[win];
    attr_sel = rgn_attr_i[int'(win)*ATTR_W +: ATTR_W];
  end

  rg_perm_eval u_perm (
    .ap_i   (ap_sel),
    .xn_i   (xn_sel),
    .kind_i (req_kind_i),
    .priv_i (req_priv_i),
    .ok_o   (rgn_ok)
  );

  always_comb begin
    active   = unit_en_i && !(req_handler_i && !handler_en_i);
    permit_c = 1'b1;
    hit_c    = 1'b0;
    region_c = '0;
    attr_c   = '0;
    if (active) begin
      if (any_hit) begin
        permit_c = rgn_ok;
        hit_c    = 1'b1;
        region_c = win;
        attr_c   = attr_sel;
      end else begin
        permit_c = req_priv_i && bg_en_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      permit_o      <= 1'b0;
      fault_o       <= 1'b0;
      fault_fetch_o <= 1'b0;
      hit_o         <= 1'b0;
      region_o      <= '0;
      attr_o        <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      permit_o      <= req_valid_i && permit_c;
      fault_o       <= req_valid_i && !permit_c;
      fault_fetch_o <= req_valid_i && !permit_c && (req_kind_i == ACC_FETCH);
      hit_o         <= req_valid_i && hit_c;
      region_o      <= req_valid_i ? region_c : '0;
      attr_o        <= req_valid_i ? attr_c : '0;
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int unsigned NREG = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [1:0]      req_kind_i,
  input logic            req_priv_i,
  input logic            req_handler_i,
  input logic            unit_en_i,
  input logic            handler_en_i,
  input logic [NREG-1:0] rgn_en_i,
  input logic            rsp_valid_o,
  input logic            permit_o,
  input logic            fault_o,
  input logic            fault_fetch_o,
  input logic            hit_o
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(rsp_valid_o || permit_o || fault_o));

  assert_one_decision_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (permit_o != fault_o));

  assert_unit_off_permits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !unit_en_i) |=> (permit_o && !hit_o));

  assert_unpriv_no_region_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && unit_en_i && !req_handler_i && !req_priv_i && rgn_en_i == '0)
      |=> fault_o);

  assert_handler_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_handler_i && !handler_en_i) |=> (permit_o && !hit_o));

  assert_data_fault_type_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i != 2'd2) |=> !fault_fetch_o);
endmodule

bind region_guard region_guard_chk #(.NREG(NREG)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_kind_i    (req_kind_i),
  .req_priv_i    (req_priv_i),
  .req_handler_i (req_handler_i),
  .unit_en_i     (unit_en_i),
  .handler_en_i  (handler_en_i),
  .rgn_en_i      (rgn_en_i),
  .rsp_valid_o   (rsp_valid_o),
  .permit_o      (permit_o),
  .fault_o       (fault_o),
  .fault_fetch_o (fault_fetch_o),
  .hit_o         (hit_o)
);

// File: tb/sim_region_guard.sv
module sim_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = '0;
  logic          req_priv = 1'b0;
  logic          req_hnd = 1'b0;
  logic          unit_en = 1'b0, bg_en = 1'b0, hnd_en = 1'b0;

  logic          r_en   [NR];
  logic [AW-1:0] r_base [NR];
  logic [4:0]    r_size [NR];
  logic [7:0]    r_srd  [NR];
  logic [2:0]    r_ap   [NR];
  logic          r_xn   [NR];
  logic [5:0]    r_attr [NR];

  logic [NR-1:0]    f_en, f_xn;
  logic [NR*AW-1:0] f_base;
  logic [NR*5-1:0]  f_size;
  logic [NR*8-1:0]  f_srd;
  logic [NR*3-1:0]  f_ap;
  logic [NR*6-1:0]  f_attr;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      f_en[i]          = r_en[i];
      f_xn[i]          = r_xn[i];
      f_base[i*AW +: AW] = r_base[i];
      f_size[i*5 +: 5] = r_size[i];
      f_srd[i*8 +: 8]  = r_srd[i];
      f_ap[i*3 +: 3]   = r_ap[i];
      f_attr[i*6 +: 6] = r_attr[i];
    end
  end

  logic       rsp_valid, permit, fault, fault_fetch, hit;
  logic [1:0] region;
  logic [5:0] attr;

  region_guard #(.ADDR_W(AW), .NREG(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_kind_i(req_kind),
    .req_priv_i(req_priv), .req_handler_i(req_hnd),
    .unit_en_i(unit_en), .bg_en_i(bg_en), .handler_en_i(hnd_en),
    .rgn_en_i(f_en), .rgn_base_i(f_base), .rgn_size_i(f_size), .rgn_srd_i(f_srd),
    .rgn_ap_i(f_ap), .rgn_xn_i(f_xn), .rgn_attr_i(f_attr),
    .rsp_valid_o(rsp_valid), .permit_o(permit), .fault_o(fault),
    .fault_fetch_o(fault_fetch), .hit_o(hit), .region_o(region), .attr_o(attr)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // permission tables indexed by code: bit n = code n allowed
  localparam logic [7:0] RD_PRIV   = 8'b1110_1110;
  localparam logic [7:0] RD_UNPRIV = 8'b1100_1100;
  localparam logic [7:0] WR_PRIV   = 8'b0000_1110;
  localparam logic [7:0] WR_UNPRIV = 8'b0000_1000;

  function automatic void model(input logic [AW-1:0] a, input int kind, input bit priv,
                                input bit hnd, output bit perm, output bit h, output int w);
    longint unsigned len, start, off;
    int sub;
    bit rd, wr;
    h = 0; w = 0;
    if (!unit_en || (hnd && !hnd_en)) begin
      perm = 1; return;
    end
    for (int r = 0; r < NR; r++) begin
      if (r_en[r]) begin
        len   = 64'd1 << (r_size[r] + 1);
        start = longint'(r_base[r]) / len * len;
        if (longint'(a) >= start && longint'(a) < start + len) begin
          off = longint'(a) - start;
          sub = int'(off / (len / 8));
          if (!(len > 256 && r_srd[r][sub])) begin
            h = 1; w = r;
          end
        end
      end
    end
    if (!h) begin
      perm = priv && bg_en; return;
    end
    rd = priv ? RD_PRIV[r_ap[w]] : RD_UNPRIV[r_ap[w]];
    wr = priv ? WR_PRIV[r_ap[w]] : WR_UNPRIV[r_ap[w]];
    if (kind == 1) perm = wr;
    else if (kind == 2) perm = rd && !r_xn[w];
    else perm = rd;
  endfunction

  task automatic access(input logic [AW-1:0] a, input int kind, input bit priv,
                        input bit hnd, input string tag);
    bit ep, eh; int ew;
    req_valid = 1; req_addr = a; req_kind = 2'(kind); req_priv = priv; req_hnd = hnd;
    @(negedge clk);
    model(a, kind, priv, hnd, ep, eh, ew);
    checks++;
    if (!rsp_valid || permit != ep || fault != !ep || hit != eh ||
        (eh && (int'(region) != ew || attr != r_attr[ew])) || (!eh && (region != 0 || attr != 0))) begin
      fails++;
      $display("FAIL %s addr=%h kind=%0d priv=%0d hnd=%0d: got v=%0d p=%0d f=%0d h=%0d r=%0d at=%h exp p=%0d h=%0d r=%0d",
               tag, a, kind, priv, hnd, rsp_valid, permit, fault, hit, region, attr, ep, eh, ew);
    end
    checks++;  // R10
    if (fault_fetch != (!ep && kind == 2)) begin
      fails++;
      $display("FAIL R10 addr=%h kind=%0d: fault_fetch got %0d exp %0d", a, kind, fault_fetch, !ep && kind == 2);
    end
  endtask

  task automatic sweep(input logic [AW-1:0] lo, input int step, input int cnt,
                       input bit hnd, input string tag);
    for (int i = 0; i < cnt; i++)
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < 2; p++)
          access(lo + AW'(i * step), k, p[0], hnd, tag);
  endtask

  task automatic idle_check();
    req_valid = 0;
    @(negedge clk);
    checks++;
    if (rsp_valid || permit || fault) begin
      fails++;
      $display("FAIL R1 idle: got v=%0d p=%0d f=%0d exp 0 0 0", rsp_valid, permit, fault);
    end
  endtask

  task automatic clear_regions();
    for (int i = 0; i < NR; i++) begin
      r_en[i] = 0; r_base[i] = '0; r_size[i] = 5'd4; r_srd[i] = '0;
      r_ap[i] = 3'd0; r_xn[i] = 0; r_attr[i] = 6'(i + 8);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_regions();
    @(negedge clk);
    checks++;  // R11
    if (rsp_valid || permit || fault || fault_fetch || hit || region != 0 || attr != 0) begin
      fails++;
      $display("FAIL R11 reset: got v=%0d p=%0d f=%0d ff=%0d h=%0d exp all 0",
               rsp_valid, permit, fault, fault_fetch, hit);
    end
    @(negedge clk);
    rst_ni = 1;
    unit_en = 1;

    // R2 R7: misaligned base, every permission code
    r_en[0] = 1; r_base[0] = 32'h2000_0040; r_size[0] = 5'd8; r_attr[0] = 6'h06;
    for (int ap = 0; ap < 8; ap++) begin
      r_ap[0] = 3'(ap);
      sweep(32'h1FFF_FF80, 32, 28, 0, "R2/R7 span+perm");
    end
    idle_check();

    // R8: execute-never on top of each code
    r_xn[0] = 1;
    for (int ap = 0; ap < 8; ap++) begin
      r_ap[0] = 3'(ap);
      sweep(32'h2000_0000, 128, 4, 0, "R8 xn");
    end

    // R3: slice disables, size threshold
    clear_regions();
    r_en[1] = 1; r_base[1] = 32'h3000_0000; r_size[1] = 5'd9; r_srd[1] = 8'h7E; r_ap[1] = 3'd3;
    sweep(32'h2FFF_FF80, 64, 20, 0, "R3 1KB slices");
    r_size[1] = 5'd8; r_srd[1] = 8'hFF;
    sweep(32'h3000_0000, 32, 16, 0, "R3 512B all off");
    r_size[1] = 5'd7; r_srd[1] = 8'hFF;
    sweep(32'h2FFF_FFE0, 32, 10, 0, "R3 256B ignored");
    idle_check();

    // R4: nested overlap, disabled top region, then a catch-all top region
    clear_regions();
    r_en[0] = 1; r_base[0] = 32'h4000_0000; r_size[0] = 5'd11; r_ap[0] = 3'd0;
    r_en[1] = 1; r_base[1] = 32'h4000_0400; r_size[1] = 5'd8;  r_ap[1] = 3'd6;
    r_en[2] = 1; r_base[2] = 32'h4000_0400; r_size[2] = 5'd7;  r_ap[2] = 3'd3; r_xn[2] = 1;
    r_en[3] = 0; r_base[3] = 32'h0;         r_size[3] = 5'd31; r_ap[3] = 3'd3;
    sweep(32'h3FFF_FF00, 128, 40, 0, "R4 overlap");
    r_en[3] = 1;
    sweep(32'h4000_0300, 256, 6, 0, "R4 catch-all");
    r_en[3] = 0;

    // R9: handler bypass and handler checking
    hnd_en = 0;
    sweep(32'h3FFF_FF00, 256, 20, 1, "R9 bypass");
    hnd_en = 1;
    sweep(32'h3FFF_FF00, 256, 20, 1, "R9 checked");
    hnd_en = 0;

    // R5: unit off
    unit_en = 0;
    sweep(32'h3FFF_FF00, 256, 20, 0, "R5 unit off");
    unit_en = 1;

    // R6: background map
    clear_regions();
    bg_en = 1;
    sweep(32'h1000_0000, 32'h0100_0000, 6, 0, "R6 bg on");
    bg_en = 0;
    sweep(32'h1000_0000, 32'h0100_0000, 6, 0, "R6 bg off");
    r_en[2] = 1; r_base[2] = 32'h6000_0000; r_size[2] = 5'd4; r_ap[2] = 3'd3; bg_en = 1;
    sweep(32'h5FFF_FFE0, 16, 8, 0, "R6 beside region");
    idle_check();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule